// File: doc/BRIEF.md
# Register-Target Conditional Branch and Link Unit

This execute-stage block resolves the two branch instructions of a simple load-store processor: a plain branch and a branch that also records a return address. Both jump only to an address held in a general register. The block takes a decoded instruction word, the two register read values chosen by that word, and the already-advanced program counter. It drives a program counter load strobe with its target and a register-file write port for the link value. The branch condition is selected by the three low bits of the instruction's count field. It tests the zero or sign state of a register, not a flags register.

A small sequencer orders the work. In `ST_IDLE` the unit shows `ready` and accepts an issue. A plain branch moves `ST_IDLE -> ST_JUMP`. A linking branch moves `ST_IDLE -> ST_LINK -> ST_JUMP`, so the return address is written one cycle before any redirect. `ST_JUMP -> ST_IDLE` follows unconditionally. An issue with any other opcode keeps the unit in `ST_IDLE` (`ST_IDLE -> ST_IDLE`). In `ST_JUMP` the program counter load strobe is raised only when the condition held at issue time. The link write takes place whether or not the branch is taken.

Top module: `brl_unit`

## Requirements
- R1: After reset `ready` is 1 and `pc_load` and `link_we` are 0.
- R2: Condition code 000 never takes the branch, 001 always takes it, and codes 110 and 111 behave as never.
- R3: Code 010 takes the branch when `rc_val` is zero; code 011 takes it when `rc_val` is non-zero.
- R4: Code 100 takes the branch when bit 31 of `rc_val` is 0; code 101 takes it when bit 31 is 1.
- R5: `pc_target` equals the `rb_val` sampled at issue; the target never comes from the instruction word.
- R6: For a linking branch (opcode `instr[31:27]` = 9), `link_we` is high for exactly one cycle, the cycle after the issue edge, with `link_idx` = `instr[26:22]` and `link_data` = the `pc_now` sampled at issue. This happens whether or not the branch is taken.
- R7: A plain branch (opcode 8) raises `pc_load` in the cycle after the issue edge. A linking branch raises it one cycle after its link write. In both cases the strobe is raised only if the condition is met.
- R8: Only `instr[2:0]` selects the condition; `instr[11:3]` has no effect on the result.
- R9: An issue whose opcode is neither 8 nor 9 produces no strobe and leaves `ready` high.
- R10: `ready` is low while a branch is in `ST_LINK` or `ST_JUMP`; an issue made while `ready` is low is ignored.
- R11: A plain branch never raises `link_we`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue | input | 1 | Instruction presented this cycle |
| instr | input | 32 | Instruction word |
| rb_val | input | 32 | Value of the target register |
| rc_val | input | 32 | Value of the tested register |
| pc_now | input | 32 | Already-advanced program counter |
| ready | output | 1 | Unit idle and able to accept an issue |
| pc_load | output | 1 | Load the program counter with `pc_target` |
| pc_target | output | 32 | Branch destination |
| link_we | output | 1 | Write `link_data` into register `link_idx` |
| link_idx | output | 5 | Link destination register number |
| link_data | output | 32 | Return address to be written |

## Verification
All results are registered. For a plain branch, `pc_load` appears in the cycle that follows the issue edge. For a linking branch, `link_we` appears in that cycle and `pc_load` in the next, and `ready` stays low for one or two cycles to match. The bench's behavioural model books each expected strobe against the cycle index it falls in. Every output is compared at the falling edge of each cycle, so the strobes are checked for being present when due and absent in every other cycle.

// File: rtl/brl_pkg.sv
package brl_pkg;
    // Instruction field positions that the decoder relies on
    localparam int OP_HI = 31;
    localparam int OP_LO = 27;
    localparam int RA_HI = 26;
    localparam int RA_LO = 22;
    localparam int CC_W  = 3;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LINK = 2'd1,
        ST_JUMP = 2'd2
    } seq_state_e;

    typedef enum logic [CC_W-1:0] {
        CC_NEVER   = 3'd0,
        CC_ALWAYS  = 3'd1,
        CC_ZERO    = 3'd2,
        CC_NONZERO = 3'd3,
        CC_NONNEG  = 3'd4,
        CC_NEG     = 3'd5,
        CC_RSV6    = 3'd6,
        CC_RSV7    = 3'd7
    } cond_e;
endpackage

// File: rtl/brl_decode.sv
module brl_decode
    import brl_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int OPW     = 5,
    parameter int RAW     = 5,
    parameter int OPC_BR  = 8,
    parameter int OPC_BRL = 9
) (
    input  logic [XLEN-1:0] instr,
    output logic            is_br,
    output logic            is_brl,
    output cond_e           cc,
    output logic [RAW-1:0]  ra_idx
);
    logic [OPW-1:0] opc;
    logic           unused_fields;

    assign opc    = instr[OP_HI:OP_LO];
    assign ra_idx = instr[RA_HI:RA_LO];
    assign cc     = cond_e'(instr[CC_W-1:0]);
    assign is_br  = (opc == OPC_BR[OPW-1:0]);
    assign is_brl = (opc == OPC_BRL[OPW-1:0]);
    // operand index fields and the upper count bits do not affect this unit
    assign unused_fields = ^instr[RA_LO-1:CC_W];
endmodule

// File: rtl/brl_cond.sv
module brl_cond
    import brl_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  cond_e           cc,
    input  logic [XLEN-1:0] rc_val,
    output logic            take
);
    logic is_zero;
    logic is_neg;

    assign is_zero = (rc_val == '0);
    assign is_neg  = rc_val[XLEN-1];

    always_comb begin
        unique case (cc)
            CC_NEVER:   take = 1'b0;
            CC_ALWAYS:  take = 1'b1;
            CC_ZERO:    take = is_zero;
            CC_NONZERO: take = !is_zero;
            CC_NONNEG:  take = !is_neg;
            CC_NEG:     take = is_neg;
            CC_RSV6:    take = 1'b0;
            CC_RSV7:    take = 1'b0;
            default:    take = 1'b0;
        endcase
    end
endmodule

// File: rtl/brl_seq.sv
module brl_seq
    import brl_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int RAW  = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            issue,
    input  logic            is_br,
    input  logic            is_brl,
    input  logic            take,
    input  logic [RAW-1:0]  ra_idx,
    input  logic [XLEN-1:0] rb_val,
    input  logic [XLEN-1:0] pc_now,
    output logic            ready,
    output logic            pc_load,
    output logic [XLEN-1:0] pc_target,
    output logic            link_we,
    output logic [RAW-1:0]  link_idx,
    output logic [XLEN-1:0] link_data
);
    seq_state_e st_q, st_d;
    logic       take_q;
    logic       accept;

    assign accept = issue && (st_q == ST_IDLE);

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (accept && is_brl)     st_d = ST_LINK;
                else if (accept && is_br) st_d = ST_JUMP;
            end
            ST_LINK: st_d = ST_JUMP;
            ST_JUMP: st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // operand capture at the accepting edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            take_q    <= 1'b0;
            pc_target <= '0;
            link_idx  <= '0;
            link_data <= '0;
        end else if (accept && (is_br || is_brl)) begin
            take_q    <= take;
            pc_target <= rb_val;
            link_idx  <= ra_idx;
            link_data <= pc_now;
        end
    end

    always_comb begin
        ready   = 1'b0;
        pc_load = 1'b0;
        link_we = 1'b0;
        unique case (st_q)
            ST_IDLE: ready   = 1'b1;
            ST_LINK: link_we = 1'b1;
            ST_JUMP: pc_load = take_q;
            default: ready   = 1'b0;
        endcase
    end

    a_r6_strobes_apart: assert property (@(posedge clk) disable iff (!rst_n)
        !(link_we && pc_load));
    a_r7_link_before_jump: assert property (@(posedge clk) disable iff (!rst_n)
        link_we |=> (!link_we && !ready));
    a_r9_other_opc_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && issue && !is_br && !is_brl) |=> ready);
    a_r11_br_no_link: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && issue && is_br) |=> (!link_we && !ready));
    a_r10_busy_returns: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |=> ready);
endmodule

// File: rtl/brl_unit.sv
module brl_unit
    import brl_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int RAW     = 5,
    parameter int OPW     = 5,
    parameter int OPC_BR  = 8,
    parameter int OPC_BRL = 9
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            issue,
    input  logic [XLEN-1:0] instr,
    input  logic [XLEN-1:0] rb_val,
    input  logic [XLEN-1:0] rc_val,
    input  logic [XLEN-1:0] pc_now,
    output logic            ready,
    output logic            pc_load,
    output logic [XLEN-1:0] pc_target,
    output logic            link_we,
    output logic [RAW-1:0]  link_idx,
    output logic [XLEN-1:0] link_data
);
    logic           is_br;
    logic           is_brl;
    cond_e          cc;
    logic [RAW-1:0] ra_idx;
    logic           take;

    brl_decode #(.XLEN(XLEN), .OPW(OPW), .RAW(RAW),
                 .OPC_BR(OPC_BR), .OPC_BRL(OPC_BRL)) u_dec (
        .instr  (instr),
        .is_br  (is_br),
        .is_brl (is_brl),
        .cc     (cc),
        .ra_idx (ra_idx)
    );

    brl_cond #(.XLEN(XLEN)) u_cond (
        .cc     (cc),
        .rc_val (rc_val),
        .take   (take)
    );

    brl_seq #(.XLEN(XLEN), .RAW(RAW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .issue     (issue),
        .is_br     (is_br),
        .is_brl    (is_brl),
        .take      (take),
        .ra_idx    (ra_idx),
        .rb_val    (rb_val),
        .pc_now    (pc_now),
        .ready     (ready),
        .pc_load   (pc_load),
        .pc_target (pc_target),
        .link_we   (link_we),
        .link_idx  (link_idx),
        .link_data (link_data)
    );

    // R4: a sign-based test taken on an accepted branch must agree with bit 31
    a_r4_sign_test: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && issue && (is_br || is_brl) && cc == CC_NEG) |-> (take == rc_val[XLEN-1]));
endmodule

// File: tb/tb_brl_unit.sv
module tb_brl_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue = 1'b0;
    logic [31:0] instr = '0, rb_val = '0, rc_val = '0, pc_now = '0;
    logic        ready, pc_load, link_we;
    logic [31:0] pc_target, link_data;
    logic [4:0]  link_idx;

    int    compared = 0, mismatched = 0, now = 0, m_left = 0;
    string cur_req = "R1";
    bit          e_pc[int];
    logic [31:0] e_tgt[int], e_ld[int];
    bit          e_lk[int];
    logic [4:0]  e_la[int];

    always #2 clk = ~clk;

    brl_unit dut (.clk(clk), .rst_n(rst_n), .issue(issue), .instr(instr),
        .rb_val(rb_val), .rc_val(rc_val), .pc_now(pc_now), .ready(ready),
        .pc_load(pc_load), .pc_target(pc_target), .link_we(link_we),
        .link_idx(link_idx), .link_data(link_data));

    function automatic bit ref_take(input logic [2:0] code, input logic [31:0] v);
        case (code)
            3'd1: return 1'b1;
            3'd2: return v == 0;
            3'd3: return v != 0;
            3'd4: return $signed(v) >= 0;
            3'd5: return $signed(v) < 0;
            default: return 1'b0;
        endcase
    endfunction

    // behavioural reference: books expected strobes against cycle indices
    always @(posedge clk) begin
        if (!rst_n) m_left = 0;
        else begin
            bit idle;
            now++;
            idle = (m_left == 0);
            if (!idle) m_left--;
            if (idle && issue && instr[31:27] == 5'd8) begin
                e_pc[now] = ref_take(instr[2:0], rc_val); e_tgt[now] = rb_val; m_left = 1;
            end else if (idle && issue && instr[31:27] == 5'd9) begin
                e_lk[now] = 1'b1; e_la[now] = instr[26:22]; e_ld[now] = pc_now;
                e_pc[now+1] = ref_take(instr[2:0], rc_val); e_tgt[now+1] = rb_val; m_left = 2;
            end
        end
    end

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s cycle %0d: actual %h expected %h", req, what, now, act, exp);
        end
    endtask

    always @(negedge clk) if (rst_n) begin
        bit xp, xl;
        xp = e_pc.exists(now) ? e_pc[now] : 1'b0;
        xl = e_lk.exists(now) ? e_lk[now] : 1'b0;
        check(cur_req, "ready", 32'(ready), 32'(m_left == 0));
        check(cur_req, "pc_load", 32'(pc_load), 32'(xp));
        check(cur_req, "link_we", 32'(link_we), 32'(xl));
        if (xp) check(cur_req, "pc_target", pc_target, e_tgt[now]);
        if (xl) begin
            check(cur_req, "link_idx", 32'(link_idx), 32'(e_la[now]));
            check(cur_req, "link_data", link_data, e_ld[now]);
        end
    end

    task automatic send(input string req, input logic [4:0] op, input logic [4:0] ra,
                        input logic [11:0] c3, input logic [31:0] rbv, input logic [31:0] rcv,
                        input logic [31:0] pcv);
        @(negedge clk);
        cur_req = req;
        instr = {op, ra, 5'd3, 5'd4, c3};
        rb_val = rbv; rc_val = rcv; pc_now = pcv; issue = 1'b1;
        @(negedge clk);
        issue = 1'b0;
        rb_val = 32'hDEAD_0000; rc_val = 32'h0; pc_now = 32'hFFFF_0000;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #(4 * 200000);
        mismatched++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state seen while reset is held
        check("R1", "ready", 32'(ready), 32'd1);
        check("R1", "pc_load", 32'(pc_load), 32'd0);
        check("R1", "link_we", 32'(link_we), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        send("R2", 5'd8, 5'd1, 12'h000, 32'h0000_1000, 32'h0, 32'h10);
        send("R2", 5'd8, 5'd1, 12'h001, 32'h0000_2000, 32'h5, 32'h14);
        send("R2", 5'd8, 5'd1, 12'h006, 32'h0000_3000, 32'h0, 32'h18);
        send("R2", 5'd8, 5'd1, 12'h007, 32'h0000_3004, 32'h8000_0000, 32'h1C);
        send("R3", 5'd8, 5'd2, 12'h002, 32'h0000_4000, 32'h0, 32'h20);
        send("R3", 5'd8, 5'd2, 12'h002, 32'h0000_4004, 32'h5, 32'h24);
        send("R3", 5'd8, 5'd2, 12'h003, 32'h0000_4008, 32'h0, 32'h28);
        send("R3", 5'd8, 5'd2, 12'h003, 32'h0000_400C, 32'h1, 32'h2C);
        send("R4", 5'd8, 5'd3, 12'h004, 32'h0000_5000, 32'h7FFF_FFFF, 32'h30);
        send("R4", 5'd8, 5'd3, 12'h004, 32'h0000_5004, 32'h8000_0000, 32'h34);
        send("R4", 5'd8, 5'd3, 12'h005, 32'h0000_5008, 32'h8000_0000, 32'h38);
        send("R4", 5'd8, 5'd3, 12'h005, 32'h0000_500C, 32'h0, 32'h3C);
        send("R5", 5'd8, 5'd0, 12'h001, 32'h1234_5678, 32'h0, 32'h40);
        send("R6", 5'd9, 5'd31, 12'h000, 32'h0000_6000, 32'h0, 32'h0000_0444);
        send("R6", 5'd9, 5'd7, 12'h002, 32'h0000_6004, 32'h9, 32'h0000_0448);
        send("R7", 5'd9, 5'd12, 12'h001, 32'hCAFE_0000, 32'h0, 32'h0000_0500);
        send("R7", 5'd9, 5'd13, 12'h005, 32'hCAFE_0010, 32'hFFFF_FFFF, 32'h0000_0504);
        send("R8", 5'd8, 5'd1, 12'hFF9, 32'h0000_7000, 32'h0, 32'h60);
        send("R8", 5'd8, 5'd1, 12'hFF8, 32'h0000_7004, 32'h0, 32'h64);
        send("R9", 5'd12, 5'd4, 12'h001, 32'h0000_8000, 32'h0, 32'h70);
        send("R9", 5'd0, 5'd4, 12'h001, 32'h0000_8004, 32'h0, 32'h74);
        send("R11", 5'd8, 5'd9, 12'h001, 32'h0000_9000, 32'h0, 32'h80);
        // R10: issue held for four cycles; the busy-cycle issues must be ignored
        @(negedge clk);
        cur_req = "R10";
        instr = {5'd9, 5'd5, 5'd3, 5'd4, 12'h001}; rb_val = 32'hA000_0000; pc_now = 32'h90; issue = 1'b1;
        @(negedge clk);
        instr = {5'd8, 5'd6, 5'd3, 5'd4, 12'h001}; rb_val = 32'hB000_0000;
        @(negedge clk);
        rb_val = 32'hB000_0004;
        @(negedge clk);
        instr = {5'd8, 5'd6, 5'd3, 5'd4, 12'h000}; rb_val = 32'hC000_0000;
        @(negedge clk);
        issue = 1'b0;
        repeat (4) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule